// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of hardware token flags that two processor ports, a left one and a right one, share. It is separate from any shared memory. Software on either side uses a flag as a lock on a shared resource that the two sides agree on. A side claims a flag by writing 0 to it. It then reads the same flag to find out whether it now holds the token.

Each flag records which side owns it, if either does. A read answers the question "do I own this flag", so the reply differs between the two sides. A request that cannot be granted yet is remembered as pending for that side. When the owner writes 1 to release the flag, the pending request takes ownership on that clock edge. A waiting side can withdraw its request by writing 1. No access ever stalls. Writes take effect on the next clock edge, and reads are answered within the same cycle.

Top module: `sem_bank`

## Requirements
- R1: After reset, every flag is free and has no pending request, so a read of any flag returns 1 on both ports.
- R2: A write of 0 by one port to a free flag makes that port the owner. From the next cycle, that port reads 0 from the flag and the other port reads 1. Read data is combinational on the port's enable and index.
- R3: While a port's enable is low, its write strobe has no effect on any flag and its read data is 1.
- R4: A write of 0 to a flag owned by the other side does not change the owner. The requester keeps reading 1 while the owner holds the flag.
- R5: If both ports write 0 to the same free flag in one cycle, the left port becomes owner and the right request becomes pending.
- R6: When the owner writes 1 while the other side has a request that is pending or arriving in the same cycle, ownership passes to the other side on that edge. From the next cycle, the new owner reads 0 and the old owner reads 1.
- R7: A write of 1 by a side whose request is pending clears that request. A later release by the owner then leaves the flag free.
- R8: A write of 1 by the non-owning side never removes ownership from the owner.
- R9: An access to one flag index leaves all other flags unchanged.
- R10: A release by the owner with no request waiting on the other side leaves the flag free, and it reads 1 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left port semaphore enable |
| l_idx | input | 3 | Left port flag index |
| l_wr | input | 1 | Left port write strobe |
| l_wd | input | 1 | Left port write bit (0 request, 1 release) |
| l_rd | output | 1 | Left port read bit (0 means left owns the indexed flag) |
| r_en | input | 1 | Right port semaphore enable |
| r_idx | input | 3 | Right port flag index |
| r_wr | input | 1 | Right port write strobe |
| r_wd | input | 1 | Right port write bit (0 request, 1 release) |
| r_rd | output | 1 | Right port read bit (0 means right owns the indexed flag) |

## Verification
A read reflects the flag state during the same cycle in which it is presented. A write changes that state at the next rising edge. A write's effect is therefore first visible to a read driven in the cycle after the write. The driver applies one access pair per cycle on the falling edge. It queues the reply expected for that same cycle, and the monitor compares the reply shortly after that falling edge, before the next rising edge. Every expected reply was worked out by hand from the requirements, and it depends only on the writes of earlier cycles.

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NF = 8,
  localparam int IW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic [IW-1:0] l_idx,
  input  logic          l_wr,
  input  logic          l_wd,
  output logic          l_rd,
  input  logic          r_en,
  input  logic [IW-1:0] r_idx,
  input  logic          r_wr,
  input  logic          r_wd,
  output logic          r_rd
);

  logic [NF-1:0] own_l, own_r, pend_l, pend_r;
  logic [NF-1:0] nx_own_l, nx_own_r, nx_pend_l, nx_pend_r;
  logic [NF-1:0] sel_l, sel_r, req_l, rel_l, req_r, rel_r;

  assign sel_l = NF'(1) << l_idx;
  assign sel_r = NF'(1) << r_idx;
  assign req_l = (l_en && l_wr && !l_wd) ? sel_l : '0;
  assign rel_l = (l_en && l_wr &&  l_wd) ? sel_l : '0;
  assign req_r = (r_en && r_wr && !r_wd) ? sel_r : '0;
  assign rel_r = (r_en && r_wr &&  r_wd) ? sel_r : '0;

  assign l_rd = l_en ? ~own_l[l_idx] : 1'b1;
  assign r_rd = r_en ? ~own_r[r_idx] : 1'b1;

  always_comb begin
    nx_own_l  = own_l;
    nx_own_r  = own_r;
    nx_pend_l = pend_l;
    nx_pend_r = pend_r;
    for (int i = 0; i < NF; i++) begin
      case ({own_l[i], own_r[i]})
        2'b00: begin
          if (req_l[i]) begin
            nx_own_l[i]  = 1'b1;
            nx_pend_r[i] = req_r[i];
            nx_pend_l[i] = 1'b0;
          end else if (req_r[i]) begin
            nx_own_r[i]  = 1'b1;
            nx_pend_l[i] = 1'b0;
            nx_pend_r[i] = 1'b0;
          end
        end
        2'b10: begin
          if (rel_l[i]) begin
            nx_own_l[i]  = 1'b0;
            nx_own_r[i]  = (pend_r[i] && !rel_r[i]) || req_r[i];
            nx_pend_r[i] = 1'b0;
          end else begin
            nx_pend_r[i] = (pend_r[i] || req_r[i]) && !rel_r[i];
          end
        end
        2'b01: begin
          if (rel_r[i]) begin
            nx_own_r[i]  = 1'b0;
            nx_own_l[i]  = (pend_l[i] && !rel_l[i]) || req_l[i];
            nx_pend_l[i] = 1'b0;
          end else begin
            nx_pend_l[i] = (pend_l[i] || req_l[i]) && !rel_l[i];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_l  <= '0;
      own_r  <= '0;
      pend_l <= '0;
      pend_r <= '0;
    end else begin
      own_l  <= nx_own_l;
      own_r  <= nx_own_r;
      pend_l <= nx_pend_l;
      pend_r <= nx_pend_r;
    end
  end

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NF = 8,
  localparam int IW = $clog2(NF)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_en,
  input logic [IW-1:0] l_idx,
  input logic          l_wr,
  input logic          l_wd,
  input logic          r_en,
  input logic [IW-1:0] r_idx,
  input logic          r_wr,
  input logic          r_wd,
  input logic [NF-1:0] own_l,
  input logic [NF-1:0] own_r,
  input logic [NF-1:0] pend_l,
  input logic [NF-1:0] pend_r
);

  logic lq, lr, rq, rr;
  assign lq = l_en && l_wr && !l_wd;
  assign lr = l_en && l_wr &&  l_wd;
  assign rq = r_en && r_wr && !r_wd;
  assign rr = r_en && r_wr &&  r_wd;

  // R2
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  // R4
  owner_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_l & pend_l) | (own_r & pend_r)) == '0);

  // R2
  left_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lq && !own_l[l_idx] && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

  // R5
  tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lq && rq && l_idx == r_idx && !own_l[l_idx] && !own_r[l_idx])
      |=> (own_l[$past(l_idx)] && pend_r[$past(l_idx)]));

  // R6
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lr && own_l[l_idx] && pend_r[l_idx] && !(rr && r_idx == l_idx))
      |=> own_r[$past(l_idx)]);

  // R8
  nonowner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rr && own_l[r_idx] && !(l_en && l_wr && l_idx == r_idx))
      |=> own_l[$past(r_idx)]);

endmodule

bind sem_bank sem_bank_chk #(.NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_idx(l_idx), .l_wr(l_wr), .l_wd(l_wd),
  .r_en(r_en), .r_idx(r_idx), .r_wr(r_wr), .r_wd(r_wd),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
  logic clk = 0;
  logic rst_n = 0;
  logic l_en = 0, l_wr = 0, l_wd = 0, r_en = 0, r_wr = 0, r_wd = 0;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic l_rd, r_rd;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sem_bank dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_idx(l_idx), .l_wr(l_wr), .l_wd(l_wd), .l_rd(l_rd),
    .r_en(r_en), .r_idx(r_idx), .r_wr(r_wr), .r_wd(r_wd), .r_rd(r_rd)
  );

  task automatic acc(input logic le, input logic [2:0] li, input logic lw, input logic ld,
                     input logic re, input logic [2:0] ri, input logic rw, input logic rd,
                     input bit chk, input logic el, input logic er, input string tag);
    @(negedge clk);
    l_en = le; l_idx = li; l_wr = lw; l_wd = ld;
    r_en = re; r_idx = ri; r_wr = rw; r_wd = rd;
    if (chk) begin
      exp_q.push_back({el, er});
      tag_q.push_back(tag);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({l_rd, r_rd} !== e) begin
        errors++;
        $display("FAIL %s: got l_rd=%b r_rd=%b expected l_rd=%b r_rd=%b",
                 t, l_rd, r_rd, e[1], e[0]);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    acc(1, 0, 0, 0, 1, 0, 0, 0, 1, 1, 1, "R1 idx0");
    acc(1, 7, 0, 0, 1, 7, 0, 0, 1, 1, 1, "R1 idx7");
    // R2: left claims flag 2
    acc(1, 2, 1, 0, 0, 0, 0, 0, 1, 1, 1, "R2 pre-write read");
    acc(1, 2, 0, 0, 1, 2, 0, 0, 1, 0, 1, "R2 left owns");
    // R4: right request while left owns
    acc(1, 2, 0, 0, 1, 2, 1, 0, 0, 0, 0, "");
    acc(1, 2, 0, 0, 1, 2, 0, 0, 1, 0, 1, "R4 right denied");
    // R7/R8: right withdraws via write 1
    acc(0, 0, 0, 0, 1, 2, 1, 1, 0, 0, 0, "");
    acc(1, 2, 0, 0, 1, 2, 0, 0, 1, 0, 1, "R8 owner kept");
    acc(1, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, "");
    acc(1, 2, 0, 0, 1, 2, 0, 0, 1, 1, 1, "R7 withdrawn, flag free");
    // R5: simultaneous claim of flag 5
    acc(1, 5, 1, 0, 1, 5, 1, 0, 0, 0, 0, "");
    acc(1, 5, 0, 0, 1, 5, 0, 0, 1, 0, 1, "R5 left wins tie");
    // R6: release hands to pending right
    acc(1, 5, 1, 1, 0, 0, 0, 0, 0, 0, 0, "");
    acc(1, 5, 0, 0, 1, 5, 0, 0, 1, 1, 0, "R6 handoff to right");
    // R3: disabled strobes ignored, disabled reads return 1
    acc(0, 3, 1, 0, 0, 5, 1, 1, 1, 1, 1, "R3 disabled read");
    acc(1, 5, 0, 0, 1, 5, 0, 0, 1, 1, 0, "R3 flag5 unchanged");
    acc(1, 3, 0, 0, 1, 3, 0, 0, 1, 1, 1, "R3 flag3 unchanged");
    // R9: independence
    acc(1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0, "");
    acc(1, 6, 0, 0, 1, 5, 0, 0, 1, 0, 0, "R9 both own distinct flags");
    acc(1, 5, 0, 0, 1, 6, 0, 0, 1, 1, 1, "R9 cross reads");
    // R10: release with nobody waiting
    acc(0, 0, 0, 0, 1, 5, 1, 1, 0, 0, 0, "");
    acc(1, 5, 0, 0, 1, 5, 0, 0, 1, 1, 1, "R10 flag5 free");
    // R6: release and same-cycle request
    acc(1, 6, 1, 1, 1, 6, 1, 0, 0, 0, 0, "");
    acc(1, 6, 0, 0, 1, 6, 0, 0, 1, 1, 0, "R6 same-cycle handoff");
    // R8: left non-owner release does not disturb right owner
    acc(1, 6, 1, 1, 0, 0, 0, 0, 0, 0, 0, "");
    acc(1, 6, 0, 0, 1, 6, 0, 0, 1, 1, 0, "R8 right keeps flag6");
    acc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule